// File: doc/BRIEF.md
# Planar-to-Semi-Planar Surface Writer

This block is a video output stage. A decoded 4:2:0 frame reaches it as three byte streams: luma (Y), blue-difference chroma (Cb) and red-difference chroma (Cr). The block writes them out through a byte-wide memory write port. The result in memory is a luma surface and one chroma surface in which Cb and Cr bytes alternate. Every surface row starts on a pitch that is rounded up to a whole multiple of 256 bytes.

A small command front end sets up each job. Each command carries a method number and a 32-bit argument. Every command, execute included, is stored in a word-indexed state file at the index given by its method number. The base-address methods hold 256-byte-granular operands, so the byte address is the argument shifted left by eight bits. A surface-size method holds the width and height, each stored as the real value minus one. An execute command starts the job. The job walks the luma plane first and then the interleaved chroma plane. It holds back the input streams whenever a memory write is still waiting for acceptance.

Top module: `yuv_surface_writer`

## Requirements
- R1: After reset, busy, err and mem_valid are low, and y_ready, cb_ready and cr_ready are low.
- R2: Method encoding is: 0 execute, 1 config base, 2 luma base, 3 chroma-U base, 4 chroma-V base, 5 surface size. The byte address used for a base is the 32-bit argument shifted left by 8.
- R3: An execute command while idle with a zero luma base raises err for exactly one cycle, starting the cycle after the command. The block stays idle and writes nothing.
- R4: An execute command while idle with frame_width or frame_height equal to zero causes no write, no err and no busy.
- R5: The surface-size word holds width-minus-one in bits [13:0] and height-minus-one in bits [29:16]. The pitch is (width+255) with its low 8 bits cleared. Luma byte c of row r, taken in raster order from the Y stream, is written to luma_base + r*pitch + c. Bytes between width and pitch are never written.
- R6: After all luma bytes, chroma is written. There are (height-minus-one)/2 rows (truncated), each holding width/2 pairs (truncated). For pair x of row r, the Cb byte goes to chroma_u_base + r*pitch + 2x and then the Cr byte goes to +2x+1. The chroma-V base has no effect.
- R7: busy rises the cycle after an accepted execute and falls the cycle after the last write is accepted. An execute command received while busy is ignored.
- R8: While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_data hold, and no input stream is accepted.
- R9: At most one of y_ready, cb_ready and cr_ready is high. Each plane stream is consumed exactly for the bytes it supplies to the surface, and gaps in valid are tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_method | input | 3 | Method number (state word index) |
| cmd_arg | input | 32 | Command argument |
| frame_width | input | 16 | Width reported for the incoming frame |
| frame_height | input | 16 | Height reported for the incoming frame |
| y_valid | input | 1 | Luma byte available |
| y_data | input | 8 | Luma byte |
| y_ready | output | 1 | Luma byte taken |
| cb_valid | input | 1 | Cb byte available |
| cb_data | input | 8 | Cb byte |
| cb_ready | output | 1 | Cb byte taken |
| cr_valid | input | 1 | Cr byte available |
| cr_data | input | 8 | Cr byte |
| cr_ready | output | 1 | Cr byte taken |
| mem_valid | output | 1 | Write request pending |
| mem_addr | output | 40 | Byte write address |
| mem_data | output | 8 | Byte write data |
| mem_ready | input | 1 | Memory accepts the pending write |
| busy | output | 1 | Job in progress |
| err | output | 1 | One-cycle flag: execute with zero luma base |

## Verification
The assertions check every cycle that a stalled write request holds its address and data. They also check that the input streams are frozen during a stall, that at most one plane is ready at a time, and that the port is quiet when idle. They further check that a Cb byte always lands on an even address and a Cr byte on an odd one, and that err only appears while idle. Only the bench scenarios can show that each byte reaches its exact padded-pitch address and that the truncated chroma row and pair counts are right. The same applies to the zero-base and zero-frame early exits, to the ignored chroma-V base, and to an execute arriving mid-job having no effect.

// File: rtl/surf_pkg.sv
package surf_pkg;
  localparam int METH_W   = 3;
  localparam int NUM_METH = 6;
  localparam int ADR_SHIFT = 8;
  localparam int PITCH_LOG2 = 8;

  typedef enum logic [METH_W-1:0] {
    M_EXEC       = 3'd0,
    M_CFG_BASE   = 3'd1,
    M_LUMA_BASE  = 3'd2,
    M_CHU_BASE   = 3'd3,
    M_CHV_BASE   = 3'd4,
    M_SURF_SIZE  = 3'd5
  } meth_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LUMA  = 3'd1,
    S_CB    = 3'd2,
    S_CR    = 3'd3,
    S_DRAIN = 3'd4
  } phase_e;
endpackage

// File: rtl/surf_cmd_regs.sv
module surf_cmd_regs
  import surf_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DIM_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [METH_W-1:0] cmd_method,
  input  logic [31:0]       cmd_arg,
  output logic              exec_req,
  output logic [ADDR_W-1:0] luma_base,
  output logic [ADDR_W-1:0] chroma_base,
  output logic [DIM_W-1:0]  width_m1,
  output logic [DIM_W-1:0]  height_m1
);
  localparam int HGT_LSB = 16;

  logic [NUM_METH-1:0] wr_en;
  logic [31:0]         word_q [NUM_METH];

  always_comb begin
    for (int i = 0; i < NUM_METH; i++) begin
      wr_en[i] = cmd_valid && (cmd_method == METH_W'(i));
    end
  end

  for (genvar g = 0; g < NUM_METH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else if (wr_en[g]) begin
        word_q[g] <= cmd_arg;
      end
    end
  end

  assign exec_req    = wr_en[int'(M_EXEC)];
  assign luma_base   = ADDR_W'({word_q[int'(M_LUMA_BASE)], {ADR_SHIFT{1'b0}}});
  assign chroma_base = ADDR_W'({word_q[int'(M_CHU_BASE)], {ADR_SHIFT{1'b0}}});
  assign width_m1    = word_q[int'(M_SURF_SIZE)][DIM_W-1:0];
  assign height_m1   = word_q[int'(M_SURF_SIZE)][HGT_LSB +: DIM_W];

  logic unused_words;
  assign unused_words = ^{word_q[int'(M_EXEC)], word_q[int'(M_CFG_BASE)],
                          word_q[int'(M_CHV_BASE)],
                          word_q[int'(M_SURF_SIZE)][31:HGT_LSB+DIM_W],
                          word_q[int'(M_SURF_SIZE)][HGT_LSB-1:DIM_W]};
endmodule

// File: rtl/surf_wr_stage.sv
module surf_wr_stage #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              mem_ready,
  output logic              load_ok,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data
);
  logic              v_d;
  logic [ADDR_W-1:0] a_d;
  logic [7:0]        d_d;

  assign load_ok = !mem_valid || mem_ready;

  always_comb begin
    v_d = mem_valid;
    a_d = mem_addr;
    d_d = mem_data;
    if (ld_en) begin
      v_d = 1'b1;
      a_d = ld_addr;
      d_d = ld_data;
    end else if (mem_ready) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      mem_valid <= v_d;
      mem_addr  <= a_d;
      mem_data  <= d_d;
    end
  end
endmodule

// File: rtl/surf_seq.sv
module surf_seq
  import surf_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DIM_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_req,
  input  logic [ADDR_W-1:0] luma_base,
  input  logic [ADDR_W-1:0] chroma_base,
  input  logic [DIM_W-1:0]  width_m1,
  input  logic [DIM_W-1:0]  height_m1,
  input  logic [15:0]       frame_width,
  input  logic [15:0]       frame_height,
  input  logic              load_ok,
  input  logic              y_valid,
  input  logic              cb_valid,
  input  logic              cr_valid,
  output logic              y_ready,
  output logic              cb_ready,
  output logic              cr_ready,
  output logic              ld_en,
  output logic [ADDR_W-1:0] ld_addr,
  output logic              busy,
  output logic              err
);
  localparam int PW = DIM_W + 1;
  localparam logic [PW-1:0] PAD = PW'((1 << PITCH_LOG2) - 1);

  phase_e            st_q, st_d;
  logic [DIM_W-1:0]  col_q, col_d, row_q, row_d;
  logic [DIM_W-1:0]  wm1_q, wm1_d, hm1_q, hm1_d;
  logic [ADDR_W-1:0] rbase_q, rbase_d, cbase_q, cbase_d;
  logic              err_d;

  logic [PW-1:0]     w_full, pitch;
  logic [DIM_W-1:0]  half_w, crow;
  logic              has_chroma, last_col, last_row, last_pair, last_crow;
  logic              y_hs, cb_hs, cr_hs;

  always_comb begin
    w_full     = {1'b0, wm1_q} + PW'(1);
    pitch      = (w_full + PAD) & ~PAD;
    half_w     = w_full[PW-1:1];
    crow       = hm1_q >> 1;
    has_chroma = (half_w != '0) && (crow != '0);
    last_col   = (col_q == wm1_q);
    last_row   = (row_q == hm1_q);
    last_pair  = (col_q == half_w - DIM_W'(1));
    last_crow  = (row_q == crow - DIM_W'(1));
  end

  assign y_ready  = (st_q == S_LUMA) && load_ok;
  assign cb_ready = (st_q == S_CB)   && load_ok;
  assign cr_ready = (st_q == S_CR)   && load_ok;
  assign y_hs     = y_ready  && y_valid;
  assign cb_hs    = cb_ready && cb_valid;
  assign cr_hs    = cr_ready && cr_valid;
  assign ld_en    = y_hs || cb_hs || cr_hs;
  assign busy     = (st_q != S_IDLE);

  always_comb begin
    unique case (st_q)
      S_LUMA:  ld_addr = rbase_q + ADDR_W'(col_q);
      S_CB:    ld_addr = rbase_q + ADDR_W'({col_q, 1'b0});
      S_CR:    ld_addr = rbase_q + ADDR_W'({col_q, 1'b1});
      default: ld_addr = rbase_q;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    col_d   = col_q;
    row_d   = row_q;
    wm1_d   = wm1_q;
    hm1_d   = hm1_q;
    rbase_d = rbase_q;
    cbase_d = cbase_q;
    err_d   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (exec_req) begin
          if (luma_base == '0) begin
            err_d = 1'b1;
          end else if ((frame_width != '0) && (frame_height != '0)) begin
            st_d    = S_LUMA;
            col_d   = '0;
            row_d   = '0;
            rbase_d = luma_base;
            cbase_d = chroma_base;
            wm1_d   = width_m1;
            hm1_d   = height_m1;
          end
        end
      end
      S_LUMA: begin
        if (y_hs) begin
          if (last_col) begin
            col_d   = '0;
            rbase_d = rbase_q + ADDR_W'(pitch);
            if (last_row) begin
              if (has_chroma) begin
                st_d    = S_CB;
                row_d   = '0;
                rbase_d = cbase_q;
              end else begin
                st_d = S_DRAIN;
              end
            end else begin
              row_d = row_q + DIM_W'(1);
            end
          end else begin
            col_d = col_q + DIM_W'(1);
          end
        end
      end
      S_CB: begin
        if (cb_hs) st_d = S_CR;
      end
      S_CR: begin
        if (cr_hs) begin
          st_d = S_CB;
          if (last_pair) begin
            col_d   = '0;
            rbase_d = rbase_q + ADDR_W'(pitch);
            if (last_crow) st_d = S_DRAIN;
            else           row_d = row_q + DIM_W'(1);
          end else begin
            col_d = col_q + DIM_W'(1);
          end
        end
      end
      S_DRAIN: begin
        if (load_ok) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      col_q   <= '0;
      row_q   <= '0;
      wm1_q   <= '0;
      hm1_q   <= '0;
      rbase_q <= '0;
      cbase_q <= '0;
      err     <= 1'b0;
    end else begin
      st_q    <= st_d;
      col_q   <= col_d;
      row_q   <= row_d;
      wm1_q   <= wm1_d;
      hm1_q   <= hm1_d;
      rbase_q <= rbase_d;
      cbase_q <= cbase_d;
      err     <= err_d;
    end
  end
endmodule

// File: rtl/yuv_surface_writer.sv
module yuv_surface_writer
  import surf_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DIM_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_method,
  input  logic [31:0]       cmd_arg,
  input  logic [15:0]       frame_width,
  input  logic [15:0]       frame_height,
  input  logic              y_valid,
  input  logic [7:0]        y_data,
  output logic              y_ready,
  input  logic              cb_valid,
  input  logic [7:0]        cb_data,
  output logic              cb_ready,
  input  logic              cr_valid,
  input  logic [7:0]        cr_data,
  output logic              cr_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  input  logic              mem_ready,
  output logic              busy,
  output logic              err
);
  logic              exec_req, load_ok, ld_en;
  logic [ADDR_W-1:0] luma_base, chroma_base, ld_addr;
  logic [DIM_W-1:0]  width_m1, height_m1;
  logic [7:0]        ld_data;

  surf_cmd_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_method(cmd_method),
    .cmd_arg(cmd_arg), .exec_req(exec_req), .luma_base(luma_base),
    .chroma_base(chroma_base), .width_m1(width_m1), .height_m1(height_m1)
  );

  surf_seq #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .exec_req(exec_req), .luma_base(luma_base),
    .chroma_base(chroma_base), .width_m1(width_m1), .height_m1(height_m1),
    .frame_width(frame_width), .frame_height(frame_height), .load_ok(load_ok),
    .y_valid(y_valid), .cb_valid(cb_valid), .cr_valid(cr_valid),
    .y_ready(y_ready), .cb_ready(cb_ready), .cr_ready(cr_ready),
    .ld_en(ld_en), .ld_addr(ld_addr), .busy(busy), .err(err)
  );

  always_comb begin
    if (y_ready)       ld_data = y_data;
    else if (cb_ready) ld_data = cb_data;
    else               ld_data = cr_data;
  end

  surf_wr_stage #(.ADDR_W(ADDR_W)) wr_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .mem_ready(mem_ready), .load_ok(load_ok),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data)
  );
endmodule

// File: rtl/yuv_surface_writer_chk.sv
module yuv_surface_writer_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              y_ready,
  input logic              cb_valid,
  input logic              cb_ready,
  input logic              cr_valid,
  input logic              cr_ready,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_data,
  input logic              mem_ready,
  input logic              busy,
  input logic              err
);
  // R8: a stalled request keeps its contents
  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R8: no stream is accepted while a write is stalled
  p_stall_streams_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> !(y_ready || cb_ready || cr_ready));

  // R9: only one plane at a time
  p_one_plane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({y_ready, cb_ready, cr_ready}));

  // R7: idle means a quiet port
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_valid || y_ready || cb_ready || cr_ready));

  // R6: Cb lands on even, Cr on odd byte addresses
  p_cb_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_valid && cb_ready) |=> (mem_valid && !mem_addr[0]));
  p_cr_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && cr_ready) |=> (mem_valid && mem_addr[0]));

  // R3: error only follows a command and leaves the block idle
  p_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && $past(cmd_valid)));
endmodule

bind yuv_surface_writer yuv_surface_writer_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/yuv_surface_writer_tb_top.sv
module yuv_surface_writer_tb_top;
  localparam int AW = 40;
  localparam int MAXW = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_method = '0;
  logic [31:0] cmd_arg = '0;
  logic [15:0] frame_width = '0, frame_height = '0;
  logic y_valid = 1'b0, cb_valid = 1'b0, cr_valid = 1'b0;
  logic [7:0] y_data = '0, cb_data = '0, cr_data = '0;
  logic y_ready, cb_ready, cr_ready, mem_valid, busy, err;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic mem_ready = 1'b1;

  always #4 clk = ~clk;

  yuv_surface_writer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_method(cmd_method),
    .cmd_arg(cmd_arg), .frame_width(frame_width), .frame_height(frame_height),
    .y_valid(y_valid), .y_data(y_data), .y_ready(y_ready),
    .cb_valid(cb_valid), .cb_data(cb_data), .cb_ready(cb_ready),
    .cr_valid(cr_valid), .cr_data(cr_data), .cr_ready(cr_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .busy(busy), .err(err)
  );

  int n_checks = 0, n_fail = 0;
  logic [AW-1:0] ea [MAXW];
  logic [7:0]    ed [MAXW];
  int n_exp = 0, n_luma = 0, wr_n = 0;
  int luma_bad = 0, chroma_bad = 0, hold_bad = 0, busy_late = 0, busy_early = 0;
  logic [AW-1:0] bad_a, bad_ea, first_a;
  logic [7:0] bad_d, bad_ed;
  int y_idx = 0, cb_idx = 0, cr_idx = 0, cyc = 0;
  bit stall_on = 0, gap_on = 0, job_on = 0;
  bit yh = 0, cbh = 0, crh = 0, pend_drop = 0, hold_pend = 0;
  logic [AW-1:0] h_a;
  logic [7:0] h_d;

  function automatic logic [7:0] yb(int k);  return 8'(k * 7 + 1);    endfunction
  function automatic logic [7:0] cbb(int k); return 8'(k * 5 + 64);   endfunction
  function automatic logic [7:0] crb(int k); return 8'(k * 11 + 128); endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // stream sources, memory responder and write monitor
  initial begin
    forever begin
      @(negedge clk);
      if (yh)  y_idx++;
      if (cbh) cb_idx++;
      if (crh) cr_idx++;
      cyc++;
      y_valid  = gap_on ? cyc[0] : 1'b1;
      cb_valid = gap_on ? !cyc[0] : 1'b1;
      cr_valid = gap_on ? ((cyc % 3) != 1) : 1'b1;
      y_data   = yb(y_idx);
      cb_data  = cbb(cb_idx);
      cr_data  = crb(cr_idx);
      mem_ready = stall_on ? ((cyc % 3) != 0) : 1'b1;
      #3;
      yh  = y_valid && y_ready;
      cbh = cb_valid && cb_ready;
      crh = cr_valid && cr_ready;
      if (pend_drop) begin
        if (busy) busy_late++;
        pend_drop = 0;
      end
      if (job_on && !busy && wr_n < n_exp) busy_early++;
      if (hold_pend && !(mem_valid && mem_addr == h_a && mem_data == h_d)) hold_bad++;
      hold_pend = mem_valid && !mem_ready;
      h_a = mem_addr;
      h_d = mem_data;
      if (mem_valid && mem_ready) begin
        if (wr_n == 0) first_a = mem_addr;
        if (wr_n >= n_exp || mem_addr != ea[wr_n] || mem_data != ed[wr_n]) begin
          if (wr_n < n_luma) luma_bad++; else chroma_bad++;
          bad_a = mem_addr; bad_d = mem_data;
          bad_ea = (wr_n < n_exp) ? ea[wr_n] : '1;
          bad_ed = (wr_n < n_exp) ? ed[wr_n] : '0;
        end
        wr_n++;
        if (wr_n == n_exp) pend_drop = 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic send(logic [2:0] m, logic [31:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_method = m; cmd_arg = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic build(logic [AW-1:0] lb, logic [AW-1:0] cb, int w, int h);
    int pitch = ((w + 255) / 256) * 256;
    int k = 0;
    n_exp = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        ea[n_exp] = lb + AW'(r * pitch + c); ed[n_exp] = yb(r * w + c); n_exp++;
      end
    n_luma = n_exp;
    for (int r = 0; r < (h - 1) / 2; r++)
      for (int x = 0; x < w / 2; x++) begin
        ea[n_exp] = cb + AW'(r * pitch + 2 * x);     ed[n_exp] = cbb(k); n_exp++;
        ea[n_exp] = cb + AW'(r * pitch + 2 * x + 1); ed[n_exp] = crb(k); n_exp++;
        k++;
      end
  endtask

  task automatic clear_mon();
    wr_n = 0; luma_bad = 0; chroma_bad = 0; hold_bad = 0;
    busy_late = 0; busy_early = 0; y_idx = 0; cb_idx = 0; cr_idx = 0;
  endtask

  task automatic run_job(int w, int h, logic [31:0] larg, logic [31:0] carg,
                         bit stall, bit gap, bit again);
    logic [AW-1:0] lb = AW'({larg, 8'h00});
    logic [AW-1:0] cb = AW'({carg, 8'h00});
    send(3'd5, {2'b00, 14'(h - 1), 2'b00, 14'(w - 1)});
    send(3'd2, larg);
    send(3'd3, carg);
    send(3'd4, 32'h00AB_CD00);        // chroma-V base must have no effect (R6)
    send(3'd1, 32'h0000_7700);
    frame_width = 16'(w); frame_height = 16'(h);
    build(lb, cb, w, h);
    clear_mon();
    stall_on = stall; gap_on = gap;
    send(3'd0, 32'h0);
    chk(busy == 1'b1, "R7", "busy after execute", busy, 1);
    job_on = 1;
    if (again) begin
      repeat (6) @(negedge clk);
      send(3'd0, 32'h0);               // ignored while busy (R7)
    end
    for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
    job_on = 0;
    repeat (8) @(negedge clk);
    chk(wr_n == n_exp, "R5", "write count", wr_n, n_exp);
    chk(first_a == lb, "R2", "first write address", first_a, lb);
    chk(luma_bad == 0, "R5", "luma write", {bad_a, bad_d}, {bad_ea, bad_ed});
    chk(chroma_bad == 0, "R6", "chroma write", {bad_a, bad_d}, {bad_ea, bad_ed});
    chk(busy_late == 0 && busy_early == 0, "R7", "busy span", busy_late + busy_early, 0);
    chk(hold_bad == 0, "R8", "stalled request hold", hold_bad, 0);
    chk(y_idx == w * h, "R9", "Y bytes consumed", y_idx, w * h);
    chk(cb_idx == (w / 2) * ((h - 1) / 2) && cr_idx == cb_idx, "R9",
        "Cb/Cr bytes consumed", {cb_idx, cr_idx}, (w / 2) * ((h - 1) / 2));
    stall_on = 0; gap_on = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(!busy && !err && !mem_valid, "R1", "busy/err/mem_valid in reset",
        {busy, err, mem_valid}, 0);
    chk(!y_ready && !cb_ready && !cr_ready, "R1", "readies in reset",
        {y_ready, cb_ready, cr_ready}, 0);
  endtask

  task automatic t_zero_luma();
    n_exp = 0; n_luma = 0; clear_mon();
    frame_width = 16'd8; frame_height = 16'd4;
    send(3'd5, {2'b00, 14'd3, 2'b00, 14'd7});
    send(3'd2, 32'h0);
    send(3'd0, 32'h0);
    chk(err == 1'b1 && busy == 1'b0, "R3", "err raised, idle", {err, busy}, 2'b10);
    @(negedge clk);
    chk(err == 1'b0, "R3", "err is one cycle", err, 0);
    repeat (10) @(negedge clk);
    chk(wr_n == 0 && !busy, "R3", "no writes after zero base", wr_n, 0);
  endtask

  task automatic t_zero_frame();
    n_exp = 0; n_luma = 0; clear_mon();
    send(3'd2, 32'h0000_0040);
    frame_width = 16'd0; frame_height = 16'd4;
    send(3'd0, 32'h0);
    chk(!busy && !err, "R4", "zero width: idle, no err", {busy, err}, 0);
    frame_width = 16'd8; frame_height = 16'd0;
    send(3'd0, 32'h0);
    chk(!busy && !err, "R4", "zero height: idle, no err", {busy, err}, 0);
    repeat (10) @(negedge clk);
    chk(wr_n == 0, "R4", "no writes on empty frame", wr_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_zero_luma();
    t_zero_frame();
    run_job(8, 4, 32'h0000_0010, 32'h0000_0020, 0, 0, 0);        // R5 R6 basic
    run_job(300, 3, 32'h0000_0100, 32'h0000_0400, 1, 1, 1);      // R8 R9 pitch 512
    run_job(1, 5, 32'h0000_0033, 32'h0000_0044, 0, 0, 0);        // R6 no pairs
    run_job(7, 6, 32'hFFFF_FF00, 32'h0000_0800, 1, 0, 0);        // R2 wide address
    run_job(5, 2, 32'h0000_0009, 32'h0000_000A, 0, 1, 0);        // R6 zero chroma rows
    finish_run();
  end
endmodule